// File: doc/BRIEF.md
# Modulation Word Router with Gain Shift

This block accepts one 18-bit modulation word from a parallel port each time a sample strobe is raised. The word is divided into a 16-bit unsigned data value and a 2-bit destination code. The code selects which synthesizer control parameter the data value drives: amplitude, phase or frequency. A fourth code is reserved and leaves all parameters as they were.

Amplitude and phase take the data value directly. Frequency treats it as an offset. The value is first scaled by a power of two: a 4-bit gain shifts it left by that many places. It is then added to a 32-bit base tuning word that is programmed elsewhere. All three parameters are held in registers. They change only on a strobed cycle and only for the addressed destination, and they feed the downstream synthesis core.

Top module: `mod_word_router`

## Requirements
- R1: The data value is taken from `port_word[17:2]` and the destination code from `port_word[1:0]`. The data value is always unsigned.
- R2: A strobed word changes at most one parameter output. The outputs of the destinations it does not address keep their previous values.
- R3: Destination code 2'b00 loads the data value into `ampl_out`.
- R4: Destination code 2'b01 loads the data value into `phase_out`.
- R5: Destination code 2'b10 loads `freq_out` with `base_ftw` plus the data value shifted left by `gain`. The data value is zero-extended before the shift, and the sum wraps modulo 2^32.
- R6: While `rst` is high at a rising clock edge, all three parameter outputs become zero.
- R7: A word is applied only when `sample_stb` is high at a rising clock edge, and the output shows it after that same edge. With the strobe low, changes on `port_word`, `gain` or `base_ftw` do not alter any output.
- R8: Destination code 2'b11 is reserved. A strobed word carrying it changes no output.
- R9: A gain of 0 aligns the least significant bit of the data value with bit 0 of the tuning word. Each gain step doubles the weight of the data value, and bits pushed past bit 31 are lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_stb | input | 1 | Port sample strobe, one cycle per word |
| port_word | input | 18 | Data value in [17:2], destination code in [1:0] |
| gain | input | 4 | Left shift applied to the frequency offset |
| base_ftw | input | 32 | Programmed base tuning word |
| freq_out | output | 32 | Registered frequency parameter |
| phase_out | output | 16 | Registered phase parameter |
| ampl_out | output | 16 | Registered amplitude parameter |

## Verification
The bench drives the gain at both ends of its range and in between. A shifter that is off by one place, or that reverses its direction, gives a wrong sum at every gain other than zero. A base word near the top of the range forces the sum to wrap, which catches an adder that saturates or that keeps the carry. Reserved-code words and words sent with the strobe low are placed between known loads, so a decoder that leaks into a neighbouring parameter, or one that ignores the strobe, corrupts a value the bench is holding. Back-to-back strobes to different destinations, and a reset in the middle of a run, show whether the outputs stay independent and return to zero.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
  localparam int MWR_DATA_W = 16;
  localparam int MWR_DEST_W = 2;
  localparam int MWR_FTW_W  = 32;
  localparam int MWR_GAIN_W = 4;

  typedef enum logic [MWR_DEST_W-1:0] {
    DEST_AMPL  = 2'd0,
    DEST_PHASE = 2'd1,
    DEST_FREQ  = 2'd2,
    DEST_RSVD  = 2'd3
  } mwr_dest_e;
endpackage

// File: rtl/mwr_decode.sv
module mwr_decode #(
  parameter int DATA_W = 16,
  parameter int DEST_W = 2,
  localparam int WORD_W = DATA_W + DEST_W,
  localparam int NDEST  = 1 << DEST_W
) (
  input  logic              sample_stb,
  input  logic [WORD_W-1:0] port_word,
  output logic [DATA_W-1:0] data_val,
  output logic [NDEST-1:0]  dest_hit
);
  logic [DEST_W-1:0] dest_code;

  assign data_val  = port_word[WORD_W-1:DEST_W];
  assign dest_code = port_word[DEST_W-1:0];

  for (genvar i = 0; i < NDEST; i++) begin : g_hit
    assign dest_hit[i] = sample_stb && (dest_code == DEST_W'(i));
  end
endmodule

// File: rtl/mwr_freq_calc.sv
module mwr_freq_calc #(
  parameter int DATA_W = 16,
  parameter int FTW_W  = 32,
  parameter int GAIN_W = 4
) (
  input  logic [FTW_W-1:0]  base_ftw,
  input  logic [DATA_W-1:0] data_val,
  input  logic [GAIN_W-1:0] gain,
  output logic [FTW_W-1:0]  freq_next
);
  function automatic logic [FTW_W-1:0] scale_offset(
    input logic [DATA_W-1:0] d,
    input logic [GAIN_W-1:0] g
  );
    logic [FTW_W-1:0] wide;
    wide = FTW_W'(d);
    return wide << g;
  endfunction

  function automatic logic [FTW_W-1:0] wrap_add(
    input logic [FTW_W-1:0] a,
    input logic [FTW_W-1:0] b
  );
    return a + b;
  endfunction

  assign freq_next = wrap_add(base_ftw, scale_offset(data_val, gain));
endmodule

// File: rtl/mwr_param_reg.sv
module mwr_param_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/mod_word_router.sv
module mod_word_router
  import mwr_pkg::*;
#(
  parameter int DATA_W = MWR_DATA_W,
  parameter int DEST_W = MWR_DEST_W,
  parameter int FTW_W  = MWR_FTW_W,
  parameter int GAIN_W = MWR_GAIN_W,
  localparam int WORD_W = DATA_W + DEST_W,
  localparam int NDEST  = 1 << DEST_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_stb,
  input  logic [WORD_W-1:0] port_word,
  input  logic [GAIN_W-1:0] gain,
  input  logic [FTW_W-1:0]  base_ftw,
  output logic [FTW_W-1:0]  freq_out,
  output logic [DATA_W-1:0] phase_out,
  output logic [DATA_W-1:0] ampl_out
);
  logic [DATA_W-1:0] data_val;
  logic [NDEST-1:0]  dest_hit;
  logic [FTW_W-1:0]  freq_next;

  // Named events for the checker
  logic hit_ampl, hit_phase, hit_freq, hit_rsvd;

  mwr_decode #(.DATA_W(DATA_W), .DEST_W(DEST_W)) u_dec (
    .sample_stb (sample_stb),
    .port_word  (port_word),
    .data_val   (data_val),
    .dest_hit   (dest_hit)
  );

  assign hit_ampl  = dest_hit[DEST_AMPL];
  assign hit_phase = dest_hit[DEST_PHASE];
  assign hit_freq  = dest_hit[DEST_FREQ];
  assign hit_rsvd  = dest_hit[DEST_RSVD];

  mwr_freq_calc #(.DATA_W(DATA_W), .FTW_W(FTW_W), .GAIN_W(GAIN_W)) u_fcalc (
    .base_ftw  (base_ftw),
    .data_val  (data_val),
    .gain      (gain),
    .freq_next (freq_next)
  );

  mwr_param_reg #(.W(DATA_W)) u_ampl (
    .clk (clk), .rst (rst), .ld (hit_ampl), .d (data_val), .q (ampl_out)
  );

  mwr_param_reg #(.W(DATA_W)) u_phase (
    .clk (clk), .rst (rst), .ld (hit_phase), .d (data_val), .q (phase_out)
  );

  mwr_param_reg #(.W(FTW_W)) u_freq (
    .clk (clk), .rst (rst), .ld (hit_freq), .d (freq_next), .q (freq_out)
  );
endmodule

// File: rtl/mwr_checker.sv
module mwr_checker #(
  parameter int DATA_W = 16,
  parameter int DEST_W = 2,
  parameter int FTW_W  = 32,
  parameter int GAIN_W = 4,
  localparam int WORD_W = DATA_W + DEST_W
) (
  input logic              clk,
  input logic              rst,
  input logic              sample_stb,
  input logic [WORD_W-1:0] port_word,
  input logic [GAIN_W-1:0] gain,
  input logic [FTW_W-1:0]  base_ftw,
  input logic [FTW_W-1:0]  freq_out,
  input logic [DATA_W-1:0] phase_out,
  input logic [DATA_W-1:0] ampl_out,
  input logic              hit_ampl,
  input logic              hit_phase,
  input logic              hit_freq,
  input logic              hit_rsvd
);
  p_single_target_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit_ampl, hit_phase, hit_freq, hit_rsvd}));

  p_ampl_load_r3: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && port_word[DEST_W-1:0] == 2'd0)
      |=> (ampl_out == $past(port_word[WORD_W-1:DEST_W])) && $stable(phase_out) && $stable(freq_out));

  p_phase_load_r4: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && port_word[DEST_W-1:0] == 2'd1)
      |=> (phase_out == $past(port_word[WORD_W-1:DEST_W])) && $stable(ampl_out) && $stable(freq_out));

  p_freq_load_r5: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && port_word[DEST_W-1:0] == 2'd2)
      |=> (freq_out == $past(base_ftw) + (FTW_W'($past(port_word[WORD_W-1:DEST_W])) << $past(gain)))
          && $stable(ampl_out) && $stable(phase_out));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !sample_stb |=> $stable(freq_out) && $stable(phase_out) && $stable(ampl_out));

  p_reserved_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && port_word[DEST_W-1:0] == 2'd3)
      |=> $stable(freq_out) && $stable(phase_out) && $stable(ampl_out));
endmodule

bind mod_word_router mwr_checker #(
  .DATA_W(DATA_W), .DEST_W(DEST_W), .FTW_W(FTW_W), .GAIN_W(GAIN_W)
) u_chk (
  .clk(clk), .rst(rst), .sample_stb(sample_stb), .port_word(port_word),
  .gain(gain), .base_ftw(base_ftw), .freq_out(freq_out),
  .phase_out(phase_out), .ampl_out(ampl_out), .hit_ampl(hit_ampl),
  .hit_phase(hit_phase), .hit_freq(hit_freq), .hit_rsvd(hit_rsvd)
);

// File: tb/sim_mod_word_router.sv
`timescale 1ns/1ps
module sim_mod_word_router;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sample_stb = 1'b0;
  logic [17:0] port_word = '0;
  logic [3:0]  gain = '0;
  logic [31:0] base_ftw = '0;
  logic [31:0] freq_out;
  logic [15:0] phase_out;
  logic [15:0] ampl_out;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [31:0] m_freq = '0;
  logic [15:0] m_phase = '0;
  logic [15:0] m_ampl = '0;

  always #4 clk = ~clk;

  mod_word_router u0 (
    .clk(clk), .rst(rst), .sample_stb(sample_stb), .port_word(port_word),
    .gain(gain), .base_ftw(base_ftw), .freq_out(freq_out),
    .phase_out(phase_out), .ampl_out(ampl_out)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmp_all(input string req);
    cmp({req, " freq"}, freq_out, m_freq);
    cmp({req, " phase"}, 32'(phase_out), 32'(m_phase));
    cmp({req, " ampl"}, 32'(ampl_out), 32'(m_ampl));
  endtask

  // Model of the frequency sum, built from multiplication rather than a shift
  function automatic logic [31:0] model_freq(input logic [31:0] b, input logic [15:0] d,
                                             input logic [3:0] g);
    longint unsigned p;
    p = longint'(b) + longint'(d) * (longint'(1) << g);
    return p[31:0];
  endfunction

  // Strobe one word; outputs checked at the negedge after the loading edge
  task automatic send(input logic [15:0] d, input logic [1:0] dst,
                      input logic [3:0] g, input logic [31:0] b);
    @(negedge clk);
    port_word = {d, dst}; gain = g; base_ftw = b; sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    case (dst)
      2'd0: m_ampl = d;
      2'd1: m_phase = d;
      2'd2: m_freq = model_freq(b, d, g);
      default: ;
    endcase
  endtask

  task automatic t_reset_state;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    m_freq = '0; m_phase = '0; m_ampl = '0;
    cmp_all("R6 reset");
    rst = 1'b0;
  endtask

  task automatic t_ampl_phase;
    send(16'hA5C3, 2'd0, 4'd0, 32'h0);
    cmp_all("R3 ampl load");
    send(16'h1234, 2'd1, 4'd7, 32'hFFFF_FFFF);
    cmp_all("R4 phase load, R2 others hold");
    send(16'hFFFF, 2'd0, 4'd0, 32'h0);
    cmp_all("R1 full data value R3");
  endtask

  task automatic t_freq_gain;
    send(16'h0001, 2'd2, 4'd0, 32'h1000_0000);
    cmp_all("R9 gain 0 LSB aligned");
    send(16'h8001, 2'd2, 4'd1, 32'h0000_0010);
    cmp_all("R5 gain 1");
    send(16'hBEEF, 2'd2, 4'd9, 32'h0123_4567);
    cmp_all("R5 gain 9");
    send(16'hFFFF, 2'd2, 4'd15, 32'h0000_0000);
    cmp_all("R9 gain 15 top weight");
    send(16'h8000, 2'd2, 4'd15, 32'h0000_0001);
    cmp_all("R1 unsigned msb R9");
  endtask

  task automatic t_wrap;
    send(16'h0020, 2'd2, 4'd0, 32'hFFFF_FFF0);
    cmp_all("R5 wrap gain 0");
    send(16'hFFFF, 2'd2, 4'd15, 32'hC000_0000);
    cmp_all("R5 wrap gain 15");
  endtask

  task automatic t_reserved;
    send(16'h5A5A, 2'd3, 4'd3, 32'h7777_7777);
    cmp_all("R8 reserved code holds all");
  endtask

  task automatic t_no_strobe;
    @(negedge clk);
    port_word = {16'h0F0F, 2'd2}; gain = 4'd4; base_ftw = 32'h2222_2222;
    @(negedge clk);
    port_word = {16'h3C3C, 2'd0};
    @(negedge clk);
    port_word = {16'hC3C3, 2'd1};
    @(negedge clk);
    cmp_all("R7 strobe low ignored");
  endtask

  task automatic t_timing;
    @(negedge clk);
    port_word = {16'h4242, 2'd1}; sample_stb = 1'b1;
    @(posedge clk); #1;
    cmp("R7 updates after strobed edge", 32'(phase_out), 32'h4242);
    @(negedge clk);
    sample_stb = 1'b0;
    m_phase = 16'h4242;
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    port_word = {16'h1111, 2'd0}; sample_stb = 1'b1;
    @(negedge clk);
    port_word = {16'h2222, 2'd1}; gain = 4'd2; base_ftw = 32'h10;
    @(negedge clk);
    port_word = {16'h0003, 2'd2};
    @(negedge clk);
    sample_stb = 1'b0;
    m_ampl = 16'h1111; m_phase = 16'h2222; m_freq = model_freq(32'h10, 16'h3, 4'd2);
    cmp_all("R2 back-to-back destinations");
  endtask

  task automatic t_mid_reset;
    @(negedge clk);
    rst = 1'b1; port_word = {16'h9999, 2'd0}; sample_stb = 1'b1;
    @(negedge clk);
    rst = 1'b0; sample_stb = 1'b0;
    m_freq = '0; m_phase = '0; m_ampl = '0;
    cmp_all("R6 reset mid-run wins over strobe");
  endtask

  initial begin
    t_reset_state();
    t_ampl_phase();
    t_freq_gain();
    t_wrap();
    t_reserved();
    t_no_strobe();
    t_timing();
    t_back_to_back();
    t_mid_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule